// File: doc/BRIEF.md
# Multi-Policy Output Port Predictor

This unit sits beside one input channel of a mesh router. While the channel has no packet in flight it guesses which output port the next head flit will ask for. The router can then reserve that port ahead of time, and a correct guess lets the head skip routing and arbitration. Several guessing policies run side by side on the same state, and the one that drives the output is chosen either by a select input or by an internal selector. That selector counts how often each policy would have been right and picks the best one at the end of every fixed-length window.

The policies are:

- **Straight:** continue in the direction of travel, which suits dimension-order routing.
- **Latest:** reuse the port taken by the previous packet on this input.
- **Frequency:** take the port that has most often followed the previously used port.
- **Custom:** use a port supplied by the user.

Each time routing resolves a head flit, the unit is told the actual port. That event updates the history, the frequency counters and the per-policy hit counters.

Top module: `port_guess_unit`

## Requirements
- R1: `pred_valid` is registered. It is 1 in the cycle after a clock edge at which `chan_idle` was 1, and 0 after an edge at which `chan_idle` was 0.
- R2: The port encoding is 0 = X+, 1 = X-, 2 = Y+, 3 = Y-, 4 = local. `in_dir` uses the same encoding for the direction of travel, so 4 means injected by the core. The straight policy (code 0) predicts `in_dir`. Out-of-range codes are treated as 4.
- R3: The latest policy (code 1) predicts the last port reported with `route_done`. With no report since reset, it predicts the straight guess.
- R4: The frequency policy (code 2) keeps one saturating counter per (previous port, next port) pair. It predicts the next port with the largest count in the row of the last reported port, and ties go to the lowest port code. It falls back to the straight guess when there is no history or when that row is all zero.
- R5: The frequency counters are 4 bits wide by default and stop at 15 instead of wrapping.
- R6: The custom policy (code 3) predicts `custom_port`.
- R7: A new `pol_sel` value, or any new input, shows on `pred_port` after the next clock edge.
- R8: With `adapt_en` = 1, `pol_sel` is ignored. Each `route_done` adds one hit to every policy whose guess equalled `route_port`. At the last cycle of every window of EPOCH_CYCLES cycles, the policy with the most hits becomes active.
- R9: Hit counters clear at each window end. If no policy has more hits than the active one, the active policy is kept.
- R10: Synchronous reset clears the history, the counters and the window, sets the adaptive policy to straight, and drives `pred_port` = 0 and `pred_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_idle | input | 1 | Input channel has no packet in flight |
| in_dir | input | 3 | Direction of travel of arriving traffic |
| route_done | input | 1 | Routing resolved a head flit this cycle |
| route_port | input | 3 | Port resolved by routing |
| pol_sel | input | 2 | Manual policy select |
| adapt_en | input | 1 | Use internal hit-count selector |
| custom_port | input | 3 | User-programmed port for custom policy |
| pred_port | output | 3 | Predicted output port |
| pred_valid | output | 1 | Prediction is valid |

## Verification
The hardest situation to reach is a change of the adaptive policy at a window boundary, together with the tie rule that keeps it. Neither the hit counts nor the active policy appear on any port.

The bench sends a run of identical route reports on a straight-travelling input, so the latest and frequency policies out-score straight and custom. It then waits several windows and checks that the prediction moved from the straight port to the repeated one. Next it idles for more windows with no reports, so that every hit count is zero, and confirms the prediction does not fall back.

Frequency saturation is observed the same way. The bench drives one counter well past 15, builds a competing counter up to 5, and checks which port wins.

// File: rtl/pgu_pkg.sv
package pgu_pkg;
  localparam int NPORT = 5;
  localparam int PW    = 3;
  localparam int NPOL  = 4;
  typedef logic [PW-1:0] port_t;
  localparam port_t P_XP  = 3'd0;
  localparam port_t P_XN  = 3'd1;
  localparam port_t P_YP  = 3'd2;
  localparam port_t P_YN  = 3'd3;
  localparam port_t P_LOC = 3'd4;
  typedef enum logic [1:0] {
    POL_STRAIGHT = 2'd0,
    POL_LATEST   = 2'd1,
    POL_FREQ     = 2'd2,
    POL_CUSTOM   = 2'd3
  } policy_t;

  function automatic port_t clamp_port(input logic [PW-1:0] p);
    return (int'(p) < NPORT) ? p : P_LOC;
  endfunction
endpackage

// File: rtl/pgu_history.sv
module pgu_history
  import pgu_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  upd,
  input  port_t port_in,
  output port_t last_port,
  output logic  last_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      last_port  <= P_XP;
      last_valid <= 1'b0;
    end else if (upd) begin
      last_port  <= port_in;
      last_valid <= 1'b1;
    end
  end

  // R3: a report is captured on the next edge
  a_r3_capture: assert property (@(posedge clk) disable iff (rst)
    upd |=> (last_valid && last_port == $past(port_in)));
endmodule

// File: rtl/pgu_freq_table.sv
module pgu_freq_table
  import pgu_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  upd,
  input  port_t prev_port,
  input  logic  prev_valid,
  input  port_t act_port,
  output port_t best_port,
  output logic  best_valid
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q [NPORT][NPORT];
  logic [CNT_W-1:0] best_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPORT; i++)
        for (int j = 0; j < NPORT; j++)
          cnt_q[i][j] <= '0;
    end else if (upd && prev_valid && cnt_q[prev_port][act_port] != CNT_MAX) begin
      cnt_q[prev_port][act_port] <= cnt_q[prev_port][act_port] + 1'b1;
    end
  end

  // Row scan: strict greater-than keeps the lowest index on ties
  always_comb begin
    best_port = P_XP;
    best_cnt  = '0;
    for (int j = 0; j < NPORT; j++) begin
      if (cnt_q[prev_port][j] > best_cnt) begin
        best_cnt  = cnt_q[prev_port][j];
        best_port = port_t'(j);
      end
    end
    best_valid = prev_valid && (best_cnt != '0);
  end

  for (genvar gi = 0; gi < NPORT; gi++) begin : g_row
    for (genvar gj = 0; gj < NPORT; gj++) begin : g_col
      // R5: counters never wrap downward
      a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
        cnt_q[gi][gj] >= $past(cnt_q[gi][gj]));
    end
  end
endmodule

// File: rtl/pgu_adapt_sel.sv
module pgu_adapt_sel
  import pgu_pkg::*;
#(
  parameter int EPOCH_CYCLES = 10000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd,
  input  logic [NPOL-1:0] hit_vec,
  output policy_t         cur_pol
);
  localparam int EP_W  = (EPOCH_CYCLES > 1) ? $clog2(EPOCH_CYCLES) : 1;
  localparam int HIT_W = $clog2(EPOCH_CYCLES + 1);
  localparam logic [EP_W-1:0] EP_LAST = EP_W'(EPOCH_CYCLES - 1);

  logic [EP_W-1:0]  ep_cnt;
  logic [HIT_W-1:0] hits_q [NPOL];
  policy_t          best_pol;
  logic             ep_end;

  assign ep_end = (ep_cnt == EP_LAST);

  always_comb begin
    best_pol = cur_pol;
    for (int p = 0; p < NPOL; p++)
      if (hits_q[p] > hits_q[best_pol]) best_pol = policy_t'(p);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ep_cnt  <= '0;
      cur_pol <= POL_STRAIGHT;
      for (int p = 0; p < NPOL; p++) hits_q[p] <= '0;
    end else if (ep_end) begin
      ep_cnt  <= '0;
      cur_pol <= best_pol;
      for (int p = 0; p < NPOL; p++) hits_q[p] <= '0;
    end else begin
      ep_cnt <= ep_cnt + 1'b1;
      for (int p = 0; p < NPOL; p++)
        if (upd && hit_vec[p]) hits_q[p] <= hits_q[p] + 1'b1;
    end
  end

  // R9: policy changes only at a window boundary
  a_r9_switch_at_epoch: assert property (@(posedge clk) disable iff (rst)
    (cur_pol != $past(cur_pol)) |-> ($past(ep_cnt) == EP_LAST));

  for (genvar gp = 0; gp < NPOL; gp++) begin : g_hit
    // R8: at most one hit per cycle within the window
    a_r8_hit_bound: assert property (@(posedge clk) disable iff (rst)
      HIT_W'(ep_cnt) >= hits_q[gp]);
  end
endmodule

// File: rtl/port_guess_unit.sv
module port_guess_unit
  import pgu_pkg::*;
#(
  parameter int EPOCH_CYCLES = 10000,
  parameter int CNT_W        = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       chan_idle,
  input  logic [2:0] in_dir,
  input  logic       route_done,
  input  logic [2:0] route_port,
  input  logic [1:0] pol_sel,
  input  logic       adapt_en,
  input  logic [2:0] custom_port,
  output logic [2:0] pred_port,
  output logic       pred_valid
);
  port_t   act_port, last_port, freq_port;
  logic    last_valid, freq_valid;
  port_t   guess [NPOL];
  logic [NPOL-1:0] hit_vec;
  policy_t auto_pol, use_pol;

  assign act_port = clamp_port(route_port);

  pgu_history u_hist (
    .clk(clk), .rst(rst), .upd(route_done), .port_in(act_port),
    .last_port(last_port), .last_valid(last_valid)
  );

  pgu_freq_table #(.CNT_W(CNT_W)) u_freq (
    .clk(clk), .rst(rst), .upd(route_done),
    .prev_port(last_port), .prev_valid(last_valid), .act_port(act_port),
    .best_port(freq_port), .best_valid(freq_valid)
  );

  always_comb begin
    guess[POL_STRAIGHT] = clamp_port(in_dir);
    guess[POL_LATEST]   = last_valid ? last_port : clamp_port(in_dir);
    guess[POL_FREQ]     = freq_valid ? freq_port : clamp_port(in_dir);
    guess[POL_CUSTOM]   = clamp_port(custom_port);
  end

  for (genvar gp = 0; gp < NPOL; gp++) begin : g_hitv
    assign hit_vec[gp] = (guess[gp] == act_port);
  end

  pgu_adapt_sel #(.EPOCH_CYCLES(EPOCH_CYCLES)) u_sel (
    .clk(clk), .rst(rst), .upd(route_done), .hit_vec(hit_vec), .cur_pol(auto_pol)
  );

  assign use_pol = adapt_en ? auto_pol : policy_t'(pol_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_port  <= P_XP;
      pred_valid <= 1'b0;
    end else begin
      pred_port  <= guess[use_pol];
      pred_valid <= chan_idle;
    end
  end

  // R1: no prediction while the channel is busy
  a_r1_busy_gate: assert property (@(posedge clk) disable iff (rst)
    !chan_idle |=> !pred_valid);
  // R2: output always a legal port code
  a_r2_port_range: assert property (@(posedge clk) disable iff (rst)
    int'(pred_port) < NPORT);
endmodule

// File: tb/tb_port_guess_unit.sv
module tb_port_guess_unit;
  localparam int CLK_PERIOD = 10;
  localparam int EP = 32;

  logic clk = 0, rst = 1;
  logic chan_idle = 1, route_done = 0, adapt_en = 0;
  logic [2:0] in_dir = 0, route_port = 0, custom_port = 0, pred_port;
  logic [1:0] pol_sel = 0;
  logic pred_valid;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_guess_unit #(.EPOCH_CYCLES(EP)) dut (
    .clk(clk), .rst(rst), .chan_idle(chan_idle), .in_dir(in_dir),
    .route_done(route_done), .route_port(route_port), .pol_sel(pol_sel),
    .adapt_en(adapt_en), .custom_port(custom_port),
    .pred_port(pred_port), .pred_valid(pred_valid)
  );

  task automatic check(input logic [2:0] act, input logic [2:0] exp, input string req);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; route_done = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic settle(); repeat (2) @(negedge clk); endtask

  task automatic report(input logic [2:0] p);
    route_port = p; route_done = 1;
    @(negedge clk); route_done = 0;
  endtask

  task automatic t_reset();
    rst = 1; chan_idle = 1;
    repeat (3) @(negedge clk);
    check({2'b0, pred_valid}, 3'd0, "R10 valid in reset");
    check(pred_port, 3'd0, "R10 port in reset");
    rst = 0;
  endtask

  task automatic t_idle();
    adapt_en = 0; pol_sel = 0; in_dir = 1; chan_idle = 1; settle();
    check({2'b0, pred_valid}, 3'd1, "R1 valid when idle");
    chan_idle = 0; settle();
    check({2'b0, pred_valid}, 3'd0, "R1 invalid when busy");
    chan_idle = 1; settle();
    check({2'b0, pred_valid}, 3'd1, "R1 valid again");
  endtask

  task automatic t_straight();
    do_reset(); adapt_en = 0; pol_sel = 0;
    in_dir = 3; settle(); check(pred_port, 3'd3, "R2 straight Y-");
    in_dir = 7; settle(); check(pred_port, 3'd4, "R2 out-of-range to local");
  endtask

  task automatic t_latest();
    do_reset(); adapt_en = 0; pol_sel = 1; in_dir = 2; settle();
    check(pred_port, 3'd2, "R3 fallback straight");
    in_dir = 4; settle(); check(pred_port, 3'd4, "R3 fallback local");
    report(3); settle(); check(pred_port, 3'd3, "R3 latest port");
    report(0); settle(); check(pred_port, 3'd0, "R3 latest updated");
  endtask

  task automatic t_freq_tie();
    do_reset(); adapt_en = 0; pol_sel = 2; in_dir = 3;
    report(1); settle(); check(pred_port, 3'd3, "R4 empty row falls back");
    do_reset(); pol_sel = 2; in_dir = 0;
    report(4); report(3); report(4); report(1); report(4); settle();
    check(pred_port, 3'd1, "R4 tie to lowest");
    report(3); report(4); settle();
    check(pred_port, 3'd3, "R4 most frequent");
  endtask

  task automatic t_freq_sat();
    do_reset(); adapt_en = 0; pol_sel = 2; in_dir = 0;
    for (int i = 0; i < 21; i++) report(2);
    for (int i = 0; i < 5; i++) begin report(0); report(2); end
    settle();
    check(pred_port, 3'd2, "R5 counter saturates");
  endtask

  task automatic t_custom();
    adapt_en = 0; pol_sel = 3; custom_port = 1; settle();
    check(pred_port, 3'd1, "R6 custom X-");
    custom_port = 4; settle();
    check(pred_port, 3'd4, "R6 custom local");
  endtask

  task automatic t_switch();
    do_reset(); adapt_en = 0; in_dir = 2; custom_port = 1; pol_sel = 0;
    report(3); settle();
    @(negedge clk); pol_sel = 3;
    @(negedge clk); check(pred_port, 3'd1, "R7 switch to custom in one cycle");
    pol_sel = 1;
    @(negedge clk); check(pred_port, 3'd3, "R7 switch to latest in one cycle");
    pol_sel = 0;
    @(negedge clk); check(pred_port, 3'd2, "R7 switch to straight in one cycle");
  endtask

  task automatic t_adapt();
    in_dir = 0; custom_port = 4; pol_sel = 0; adapt_en = 1;
    do_reset(); settle();
    check(pred_port, 3'd0, "R10 adaptive starts straight");
    for (int i = 0; i < 10; i++) report(2);
    repeat (3*EP) @(negedge clk);
    check(pred_port, 3'd2, "R8 adaptive picks best");
    pol_sel = 3; settle();
    check(pred_port, 3'd2, "R8 pol_sel ignored");
    repeat (3*EP) @(negedge clk);
    check(pred_port, 3'd2, "R9 tie keeps current");
    adapt_en = 0; pol_sel = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle();
    t_straight();
    t_latest();
    t_freq_tie();
    t_freq_sat();
    t_custom();
    t_switch();
    t_adapt();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule